// File: doc/BRIEF.md
# DRAM Rank Low-Power State Controller

This block follows the power state of a single DRAM rank and decides, cycle by cycle, when the rank may drop into a low-power state and when it must be woken up. The scheduler reports each scheduled and completed burst, precharge and refresh. It also supplies the open-bank bitmap, the rank's read and write queue occupancy, the bus direction, a refresh request, a command-wake request and a read-data-return strobe. The controller keeps a count of events still in flight and allows a low-power entry only when that count is zero and both queues are empty.

Which state follows a refresh depends on the state the rank was in before it. A rank that was in active power-down returns to precharge power-down. A rank that was in precharge power-down returns there if work is queued, and otherwise drops into self-refresh. After any power-down or self-refresh exit, the controller holds off new commands for a parameterised number of cycles. A rank-idle flag tells the drain logic that the rank has all banks closed and is in no low-power state.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: After reset the state is idle, no entry or exit request is raised, rank_idle is 1 and cmd_ok is 1. The state encoding on `pwr_state` is: idle=0, active=1, refresh=2, self-refresh=3, precharge power-down=4, active power-down=5.
- R2: The outstanding-event count changes each cycle by the number of asserted schedule strobes minus the number of asserted completion strobes. A low-power entry uses the count as it stands after that cycle's strobes.
- R3: From idle or active, the rank enters precharge or active power-down only when the updated outstanding count is zero and both queue counts are zero.
- R4: In idle or active, a read-data return under the R3 condition moves the rank to active power-down if any bank is open, or to precharge power-down if all banks are closed. It raises `pd_enter` for one cycle.
- R5: In idle or active, a precharge completion with all banks closed and the R3 condition met moves the rank to precharge power-down and pulses `pd_enter`.
- R6: While in refresh, a refresh completion selects the next state from the state held before the refresh. Active power-down leads to precharge power-down with `pd_enter`. Precharge power-down leads to precharge power-down with `pd_enter` when either queue is non-empty, and otherwise to self-refresh with `sr_enter`. No prior low-power state leads to idle or active according to the banks.
- R7: In either power-down state, a refresh request moves the rank to refresh and pulses `pd_exit`. Otherwise a command request moves it to idle or active and pulses `pd_exit`. The refresh request wins when both are present.
- R8: Self-refresh is left for idle, with an `sr_exit` pulse, when the read queue is non-empty, or when the write queue is non-empty and `bus_write` is 1. Write-queue work with the bus in read mode leaves the rank in self-refresh.
- R9: From idle or active, a refresh request moves the rank to refresh only when all banks are closed. With banks open the request waits. A refresh entry takes priority over the R4 and R5 entries.
- R10: `cmd_ok` is 1 only in idle or active. It stays 0 for `T_XP` cycles after a power-down exit and for `T_XS` cycles after a self-refresh exit.
- R11: `rank_idle` is 1 exactly when the state is idle.
- R12: When no other transition applies in idle or active, the state is active if any bank is open and idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_burst | input | 1 | A read/write burst was scheduled |
| sched_pre | input | 1 | A precharge was scheduled |
| sched_ref | input | 1 | A refresh was scheduled |
| done_burst | input | 1 | A scheduled burst completed |
| done_pre | input | 1 | A scheduled precharge completed |
| done_ref | input | 1 | A scheduled refresh completed |
| rd_return | input | 1 | Read data returned from the rank |
| bank_open | input | NBANK | Open-bank bitmap |
| rdq_count | input | QW | Read-queue entries for this rank |
| wrq_count | input | QW | Write-queue entries for this rank |
| bus_write | input | 1 | Bus is in write direction |
| ref_req | input | 1 | Refresh is due (level) |
| cmd_req | input | 1 | Scheduler wants to issue a read or write |
| pwr_state | output | 3 | Current power state (encoding in R1) |
| pd_enter | output | 1 | Power-down entry request pulse |
| pd_exit | output | 1 | Power-down exit request pulse |
| sr_enter | output | 1 | Self-refresh entry request pulse |
| sr_exit | output | 1 | Self-refresh exit request pulse |
| cmd_ok | output | 1 | Commands may be issued to the rank |
| rank_idle | output | 1 | Rank is idle (all banks closed, not low-power) |

## Verification
The bench targets the cycle where a completion and a read return land together. A design that checks the count before that cycle's strobes would miss the power-down entry, and one that skips the count altogether would enter power-down with a burst still in flight. It exercises all three post-refresh branches. A design that loses the prior state would send an active-power-down rank into self-refresh, or a rank with queued work into self-refresh. The bench also drives write-queue work with the bus in read mode against self-refresh, a refresh request with banks open, and the exact cycle on which `cmd_ok` returns after each exit latency. An off-by-one exit timer shows up as an early or late `cmd_ok`.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

   typedef enum logic [2:0] {
      PS_IDLE = 3'd0,
      PS_ACT  = 3'd1,
      PS_REF  = 3'd2,
      PS_SREF = 3'd3,
      PS_PPD  = 3'd4,
      PS_APD  = 3'd5
   } pstate_e;

   typedef enum logic [1:0] {
      PRV_NONE = 2'd0,
      PRV_PPD  = 2'd1,
      PRV_APD  = 2'd2
   } prior_e;

   function automatic logic is_lowpow(pstate_e s);
      return (s == PS_SREF) || (s == PS_PPD) || (s == PS_APD);
   endfunction

endpackage

// File: rtl/rank_evt_counter.sv
module rank_evt_counter #(
   parameter int NEV   = 3,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NEV-1:0]   sched,
   input  logic [NEV-1:0]   done,
   output logic [CNT_W-1:0] cnt_nxt
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] s_sum [0:NEV];
   logic [CNT_W-1:0] d_sum [0:NEV];

   assign s_sum[0] = '0;
   assign d_sum[0] = '0;

   for (genvar g = 0; g < NEV; g++) begin : g_pop
      assign s_sum[g+1] = s_sum[g] + CNT_W'(sched[g]);
      assign d_sum[g+1] = d_sum[g] + CNT_W'(done[g]);
   end

   assign cnt_nxt = cnt_q + s_sum[NEV] - d_sum[NEV];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   // R2: the count must neither wrap past its maximum nor drop below zero
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (({1'b0, cnt_q} + {1'b0, s_sum[NEV]}) >= {1'b0, d_sum[NEV]}) &&
      (({1'b0, cnt_q} + {1'b0, s_sum[NEV]} - {1'b0, d_sum[NEV]}) < (CNT_W+1)'(2**CNT_W)));

endmodule

// File: rtl/rank_exit_timer.sv
module rank_exit_timer #(
   parameter int T_XP = 3,
   parameter int T_XS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_pd,
   input  logic ld_sr,
   output logic busy
);
   localparam int MAXL = (T_XS > T_XP) ? T_XS : T_XP;
   localparam int TW   = $clog2(MAXL + 1);

   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tmr_q <= '0;
      else if (ld_pd)          tmr_q <= TW'(T_XP);
      else if (ld_sr)          tmr_q <= TW'(T_XS);
      else if (tmr_q != '0)    tmr_q <= tmr_q - 1'b1;
   end

   assign busy = (tmr_q != '0);

   // R10: an exit always blocks commands in the following cycle
   assert_exit_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_pd || ld_sr) |=> busy);

endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
   import rank_pwr_pkg::*;
#(
   parameter int NBANK = 8,
   parameter int QW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBANK-1:0] bank_open,
   input  logic [QW-1:0]    rdq_count,
   input  logic [QW-1:0]    wrq_count,
   input  logic             bus_write,
   input  logic             ref_req,
   input  logic             cmd_req,
   input  logic             rd_return,
   input  logic             pre_done,
   input  logic             ref_done,
   input  logic             quiet,
   output pstate_e          st_q,
   output logic             pd_enter_q,
   output logic             pd_exit_q,
   output logic             sr_enter_q,
   output logic             sr_exit_q,
   output logic             wake_pd,
   output logic             wake_sr
);
   pstate_e st_d, base;
   prior_e  prv_q, prv_d;
   logic    any_open, rd_work, any_work, pde;

   assign any_open = |bank_open;
   assign rd_work  = (rdq_count != '0);
   assign any_work = rd_work || (wrq_count != '0);
   assign base     = any_open ? PS_ACT : PS_IDLE;

   always_comb begin
      st_d    = st_q;
      prv_d   = prv_q;
      pde     = 1'b0;
      wake_pd = 1'b0;
      wake_sr = 1'b0;
      sr_d    = 1'b0;
      unique case (st_q)
         PS_IDLE, PS_ACT: begin
            if (ref_req && !any_open) begin
               st_d  = PS_REF;
               prv_d = PRV_NONE;
            end else if (rd_return && quiet) begin
               st_d = any_open ? PS_APD : PS_PPD;
               pde  = 1'b1;
            end else if (pre_done && !any_open && quiet) begin
               st_d = PS_PPD;
               pde  = 1'b1;
            end else begin
               st_d = base;
            end
         end
         PS_PPD, PS_APD: begin
            if (ref_req) begin
               st_d    = PS_REF;
               prv_d   = (st_q == PS_APD) ? PRV_APD : PRV_PPD;
               wake_pd = 1'b1;
            end else if (cmd_req) begin
               st_d    = base;
               wake_pd = 1'b1;
            end
         end
         PS_REF: begin
            if (ref_done) begin
               unique case (prv_q)
                  PRV_APD: begin st_d = PS_PPD; pde = 1'b1; end
                  PRV_PPD: begin
                     if (any_work) begin st_d = PS_PPD;  pde  = 1'b1; end
                     else          begin st_d = PS_SREF; sr_d = 1'b1; end
                  end
                  default: st_d = base;
               endcase
               prv_d = PRV_NONE;
            end
         end
         PS_SREF: begin
            if (rd_work || ((wrq_count != '0) && bus_write)) begin
               st_d    = PS_IDLE;
               wake_sr = 1'b1;
            end
         end
         default: st_d = PS_IDLE;
      endcase
   end

   logic sr_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= PS_IDLE;
         prv_q      <= PRV_NONE;
         pd_enter_q <= 1'b0;
         pd_exit_q  <= 1'b0;
         sr_enter_q <= 1'b0;
         sr_exit_q  <= 1'b0;
      end else begin
         st_q       <= st_d;
         prv_q      <= prv_d;
         pd_enter_q <= pde;
         pd_exit_q  <= wake_pd;
         sr_enter_q <= sr_d;
         sr_exit_q  <= wake_sr;
      end
   end

   // R3: power-down entry from idle/active only after a quiet cycle
   assert_pd_entry_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(st_q) == PS_IDLE || $past(st_q) == PS_ACT) &&
       (st_q == PS_PPD || st_q == PS_APD)) |-> $past(quiet));

   // R6: self-refresh is only ever reached out of a refresh
   assert_sref_from_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sr_enter_q |-> ($past(st_q) == PS_REF) && (st_q == PS_SREF));

   // R8: leaving self-refresh needs read work, or write work with the bus writing
   assert_sref_exit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == PS_SREF && st_q != PS_SREF) |->
         $past(rd_work || ((wrq_count != '0) && bus_write)));

   // R7: at most one command request pulse per cycle
   assert_one_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pd_enter_q, pd_exit_q, sr_enter_q, sr_exit_q}));

   // R9: refresh is never entered from idle/active with a bank open
   assert_ref_banks_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) inside {PS_IDLE, PS_ACT} && st_q == PS_REF) |-> $past(bank_open == '0));

endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl
   import rank_pwr_pkg::*;
#(
   parameter int NBANK = 8,
   parameter int QW    = 4,
   parameter int CNT_W = 4,
   parameter int T_XP  = 3,
   parameter int T_XS  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sched_burst,
   input  logic             sched_pre,
   input  logic             sched_ref,
   input  logic             done_burst,
   input  logic             done_pre,
   input  logic             done_ref,
   input  logic             rd_return,
   input  logic [NBANK-1:0] bank_open,
   input  logic [QW-1:0]    rdq_count,
   input  logic [QW-1:0]    wrq_count,
   input  logic             bus_write,
   input  logic             ref_req,
   input  logic             cmd_req,
   output logic [2:0]       pwr_state,
   output logic             pd_enter,
   output logic             pd_exit,
   output logic             sr_enter,
   output logic             sr_exit,
   output logic             cmd_ok,
   output logic             rank_idle
);
   localparam int NEV = 3;

   if (T_XP < 1 || T_XS < 1) begin : g_bad_lat
      $error("exit latencies must be at least one cycle");
   end
   if (NBANK < 1 || QW < 1 || CNT_W < 2) begin : g_bad_width
      $error("bank, queue and counter widths out of range");
   end

   logic [CNT_W-1:0] cnt_nxt;
   logic             quiet, busy, wake_pd, wake_sr;
   pstate_e          st;

   rank_evt_counter #(.NEV(NEV), .CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .sched   ({sched_ref, sched_pre, sched_burst}),
      .done    ({done_ref, done_pre, done_burst}),
      .cnt_nxt (cnt_nxt)
   );

   assign quiet = (cnt_nxt == '0) && (rdq_count == '0) && (wrq_count == '0);

   rank_pwr_fsm #(.NBANK(NBANK), .QW(QW)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_open  (bank_open),
      .rdq_count  (rdq_count),
      .wrq_count  (wrq_count),
      .bus_write  (bus_write),
      .ref_req    (ref_req),
      .cmd_req    (cmd_req),
      .rd_return  (rd_return),
      .pre_done   (done_pre),
      .ref_done   (done_ref),
      .quiet      (quiet),
      .st_q       (st),
      .pd_enter_q (pd_enter),
      .pd_exit_q  (pd_exit),
      .sr_enter_q (sr_enter),
      .sr_exit_q  (sr_exit),
      .wake_pd    (wake_pd),
      .wake_sr    (wake_sr)
   );

   rank_exit_timer #(.T_XP(T_XP), .T_XS(T_XS)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_pd (wake_pd),
      .ld_sr (wake_sr),
      .busy  (busy)
   );

   assign pwr_state = st;
   assign cmd_ok    = !busy && (st == PS_IDLE || st == PS_ACT);
   assign rank_idle = (st == PS_IDLE);

   // R10: commands are never allowed in a low-power state or refresh
   assert_cmd_block_lp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lowpow(st) || st == PS_REF) |-> !cmd_ok);

endmodule

// File: tb/rank_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module rank_pwr_ctrl_tb;
   localparam int NBANK = 8, QW = 4, CNT_W = 4, T_XP = 3, T_XS = 10;
   localparam int S_IDLE = 0, S_ACT = 1, S_REF = 2, S_SREF = 3, S_PPD = 4, S_APD = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sched_burst, sched_pre, sched_ref, done_burst, done_pre, done_ref;
   logic rd_return, bus_write, ref_req, cmd_req;
   logic [NBANK-1:0] bank_open;
   logic [QW-1:0] rdq_count, wrq_count;
   logic [2:0] pwr_state;
   logic pd_enter, pd_exit, sr_enter, sr_exit, cmd_ok, rank_idle;

   always #2.5 clk = ~clk;

   rank_pwr_ctrl #(.NBANK(NBANK), .QW(QW), .CNT_W(CNT_W), .T_XP(T_XP), .T_XS(T_XS)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .sched_burst(sched_burst), .sched_pre(sched_pre), .sched_ref(sched_ref),
      .done_burst(done_burst), .done_pre(done_pre), .done_ref(done_ref),
      .rd_return(rd_return), .bank_open(bank_open), .rdq_count(rdq_count),
      .wrq_count(wrq_count), .bus_write(bus_write), .ref_req(ref_req), .cmd_req(cmd_req),
      .pwr_state(pwr_state), .pd_enter(pd_enter), .pd_exit(pd_exit),
      .sr_enter(sr_enter), .sr_exit(sr_exit), .cmd_ok(cmd_ok), .rank_idle(rank_idle));

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // bench model of the requirements
   int m_st = S_IDLE, m_prv = 0, m_cnt = 0, m_tmr = 0;
   bit m_pde = 0, m_pdx = 0, m_sre = 0, m_srx = 0;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int m_cmd_ok();
      return (m_tmr == 0 && (m_st == S_IDLE || m_st == S_ACT)) ? 1 : 0;
   endfunction

   function automatic void model_step();
      int nc;
      bit q, open, work;
      nc = m_cnt + sched_burst + sched_pre + sched_ref - done_burst - done_pre - done_ref;
      q = (nc == 0) && (rdq_count == 0) && (wrq_count == 0);
      open = (bank_open != 0);
      work = (rdq_count != 0) || (wrq_count != 0);
      m_pde = 0; m_pdx = 0; m_sre = 0; m_srx = 0;
      if (m_tmr > 0) m_tmr--;
      case (m_st)
         S_IDLE, S_ACT: begin
            if (ref_req && !open) begin m_st = S_REF; m_prv = 0; end
            else if (rd_return && q) begin m_st = open ? S_APD : S_PPD; m_pde = 1; end
            else if (done_pre && !open && q) begin m_st = S_PPD; m_pde = 1; end
            else m_st = open ? S_ACT : S_IDLE;
         end
         S_PPD, S_APD: begin
            if (ref_req) begin
               m_prv = (m_st == S_APD) ? 2 : 1; m_st = S_REF; m_pdx = 1; m_tmr = T_XP;
            end else if (cmd_req) begin
               m_st = open ? S_ACT : S_IDLE; m_pdx = 1; m_tmr = T_XP;
            end
         end
         S_REF: if (done_ref) begin
            if (m_prv == 2) begin m_st = S_PPD; m_pde = 1; end
            else if (m_prv == 1) begin
               if (work) begin m_st = S_PPD; m_pde = 1; end
               else begin m_st = S_SREF; m_sre = 1; end
            end else m_st = open ? S_ACT : S_IDLE;
            m_prv = 0;
         end
         default: if (rdq_count != 0 || (wrq_count != 0 && bus_write)) begin
            m_st = S_IDLE; m_srx = 1; m_tmr = T_XS;
         end
      endcase
      m_cnt = nc;
   endfunction

   task automatic compare_all();
      chk("R3 state", int'(pwr_state), m_st);
      chk("R4 pd_enter", int'(pd_enter), int'(m_pde));
      chk("R7 pd_exit", int'(pd_exit), int'(m_pdx));
      chk("R6 sr_enter", int'(sr_enter), int'(m_sre));
      chk("R8 sr_exit", int'(sr_exit), int'(m_srx));
      chk("R10 cmd_ok", int'(cmd_ok), m_cmd_ok());
      chk("R11 rank_idle", int'(rank_idle), (m_st == S_IDLE) ? 1 : 0);
   endtask

   task automatic clr();
      sched_burst = 0; sched_pre = 0; sched_ref = 0;
      done_burst = 0; done_pre = 0; done_ref = 0;
      rd_return = 0; cmd_req = 0;
   endtask

   // inputs are already set at a negedge; model advances, outputs checked at next negedge
   task automatic step();
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic dstep();
      step();
      clr();
   endtask

   initial begin
      clr();
      bank_open = 0; rdq_count = 0; wrq_count = 0; bus_write = 0; ref_req = 0;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 state", int'(pwr_state), 0);
      chk("R1 reqs", int'({pd_enter, pd_exit, sr_enter, sr_exit}), 0);
      chk("R1 rank_idle", int'(rank_idle), 1);
      chk("R1 cmd_ok", int'(cmd_ok), 1);

      // R12 banks open -> active
      bank_open = 8'h01; dstep();
      chk("R12 active", int'(pwr_state), S_ACT);
      // R2: burst in flight blocks power-down on read return
      sched_burst = 1; dstep();
      rd_return = 1; dstep();
      chk("R2 stays active with burst pending", int'(pwr_state), S_ACT);
      // R2/R4: completion in the same cycle as the return lets it enter
      rd_return = 1; done_burst = 1; dstep();
      chk("R4 active power-down", int'(pwr_state), S_APD);
      chk("R4 pd_enter", int'(pd_enter), 1);
      // R7 refresh out of active power-down
      ref_req = 1; dstep();
      chk("R7 refresh entry", int'(pwr_state), S_REF);
      chk("R7 pd_exit", int'(pd_exit), 1);
      ref_req = 0; bank_open = 0; sched_ref = 1; dstep();
      done_ref = 1; dstep();
      chk("R6 APD->REF->PPD", int'(pwr_state), S_PPD);
      // R7 command wake and R10 latency
      cmd_req = 1; dstep();
      chk("R7 wake to idle", int'(pwr_state), S_IDLE);
      for (int i = 0; i < T_XP - 1; i++) begin
         dstep();
         chk("R10 blocked after pd exit", int'(cmd_ok), 0);
      end
      dstep();
      chk("R10 released after T_XP", int'(cmd_ok), 1);
      // R5 precharge completion
      sched_pre = 1; dstep();
      done_pre = 1; dstep();
      chk("R5 precharge power-down", int'(pwr_state), S_PPD);
      // R6 PPD with queued work -> PPD
      ref_req = 1; dstep();
      ref_req = 0; sched_ref = 1; dstep();
      done_ref = 1; wrq_count = 2; dstep();
      chk("R6 queued work returns to PPD", int'(pwr_state), S_PPD);
      // R6 PPD without work -> SREF (write work with bus read must not wake: R8)
      ref_req = 1; bus_write = 0; dstep();
      ref_req = 0; wrq_count = 0; sched_ref = 1; dstep();
      done_ref = 1; dstep();
      chk("R6 self-refresh", int'(pwr_state), S_SREF);
      chk("R6 sr_enter", int'(sr_enter), 1);
      wrq_count = 3; bus_write = 0; dstep(); dstep();
      chk("R8 read-mode write work ignored", int'(pwr_state), S_SREF);
      bus_write = 1; dstep();
      chk("R8 exit to idle", int'(pwr_state), S_IDLE);
      chk("R8 sr_exit", int'(sr_exit), 1);
      wrq_count = 0; bus_write = 0;
      for (int i = 0; i < T_XS - 1; i++) dstep();
      chk("R10 still blocked before T_XS", int'(cmd_ok), 0);
      dstep();
      chk("R10 released after T_XS", int'(cmd_ok), 1);
      // R9 refresh waits for banks to close
      bank_open = 8'h30; ref_req = 1; dstep(); dstep();
      chk("R9 refresh waits", int'(pwr_state), S_ACT);
      bank_open = 0; dstep();
      chk("R9 refresh entered", int'(pwr_state), S_REF);
      ref_req = 0; sched_ref = 1; dstep();
      done_ref = 1; dstep();
      chk("R6 plain refresh to idle", int'(pwr_state), S_IDLE);

      // constrained random phase
      begin
         bit ref_sent = 0;
         for (int cyc = 0; cyc < 4000; cyc++) begin
            clr();
            rdq_count = ($urandom % 2) ? QW'($urandom % 4) : '0;
            wrq_count = ($urandom % 2) ? QW'($urandom % 4) : '0;
            bus_write = 1'($urandom % 2);
            if (!ref_req && ($urandom % 24) == 0) ref_req = 1;
            if (m_st == S_REF) ref_req = 0;
            case (m_st)
               S_IDLE, S_ACT: begin
                  if (m_cmd_ok() == 1) begin
                     if (($urandom % 4) == 0)
                        bank_open = ($urandom % 2) ? NBANK'($urandom) : '0;
                     if (m_cnt < 8) begin
                        sched_burst = 1'($urandom % 3 == 0);
                        sched_pre   = 1'($urandom % 4 == 0);
                     end
                  end
                  if (m_cnt + sched_burst + sched_pre >= 1) done_burst = 1'($urandom % 3 == 0);
                  if (m_cnt + sched_burst + sched_pre - done_burst >= 1) done_pre = 1'($urandom % 4 == 0);
                  rd_return = 1'($urandom % 4 == 0);
               end
               S_REF: begin
                  bank_open = 0;
                  if (!ref_sent) begin sched_ref = 1; ref_sent = 1; end
                  else if (($urandom % 3) == 0) begin done_ref = 1; ref_sent = 0; end
               end
               S_PPD, S_APD: cmd_req = 1'($urandom % 6 == 0);
               default: ;
            endcase
            step();
         end
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule